// File: doc/BRIEF.md
# Segmented Page Table Walker

This block turns an 18-bit virtual word address into a 20-bit physical word address. The machine it serves is word-addressed, with 36-bit words and 1K-word pages. Four table base registers divide the virtual space into four 128K segments. The segment is chosen by the privilege of the request (user or exec) and by the top address bit (low or high half). Each base register points at a 64-word page table. Every table word packs two 18-bit entries.

For each request the walker fetches the one table word it needs through a plain memory read port. It picks the halfword for the page, decodes the access code and checks it against the request type. It then returns a fault flag, or the physical address with a cacheable flag. When the page's age bit is still set on an allowed access, the walker first writes the table word back with only that age bit cleared, and only then gives the response. Only one translation is in flight at a time. A new request is taken only while `ready_o` is high.

Top module: `seg_ptw`

## Requirements
- R1: Base register index 0 serves user low, 1 user high, 2 exec high and 3 exec low. The segment is low when `req_vaddr_i[17]` is 0. A write on the base load port sets the register named by `base_idx_i`.
- R2: For an accepted request, exactly one memory read is issued, at the address base + `req_vaddr_i[16:11]` (page index divided by two). The page index is `req_vaddr_i[16:10]`.
- R3: An even page index takes its entry from table word bits [35:18]. An odd page index takes it from bits [17:0].
- R4: Within the 18-bit entry, bits [17:16] hold the access code, bit 13 the age bit, bit 12 the cacheable bit and bits [9:0] the physical page number. Bits 15:14 and 11:10 carry no meaning.
- R5: Access code 00 faults on every request. Codes 01 and 10 allow reads and fault on writes. Code 11 allows both.
- R6: On a response without a fault, `rsp_paddr_o` equals {physical page number, `req_vaddr_i[9:0]`} and `rsp_cache_o` equals the entry's cacheable bit.
- R7: On an allowed access whose age bit is 1, exactly one memory write goes to the same table address before `rsp_valid_o`. The written word equals the fetched word with only that entry's age bit cleared, and `rsp_age_clr_o` is 1.
- R8: A faulting access, or an allowed access whose age bit is 0, issues no memory write and returns `rsp_age_clr_o` = 0. A fault also returns `rsp_paddr_o` = 0 and `rsp_cache_o` = 0.
- R9: `ready_o` drops in the cycle after a request is accepted and stays low until the response. A request presented while `ready_o` is low is ignored.
- R10: After reset `ready_o` is 1, and `rsp_valid_o`, `mem_rd_o` and `mem_wr_o` are 0.
- R11: `rsp_valid_o` is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Load one base register |
| base_idx_i | input | 2 | Base register to load |
| base_data_i | input | 20 | Physical word address of a page table |
| req_i | input | 1 | Translation request |
| ready_o | output | 1 | Walker idle, request will be taken |
| req_vaddr_i | input | 18 | Virtual word address |
| req_exec_i | input | 1 | 1 for exec space, 0 for user space |
| req_write_i | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Access refused |
| rsp_paddr_o | output | 20 | Physical word address |
| rsp_cache_o | output | 1 | Page may be cached |
| rsp_age_clr_o | output | 1 | Age bit was cleared by this access |
| mem_rd_o | output | 1 | Table read, one cycle |
| mem_wr_o | output | 1 | Table write-back, one cycle |
| mem_addr_o | output | 20 | Table word address |
| mem_wdata_o | output | 36 | Write-back word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 36 | Read data |

## Verification
A wrong base selection or table index shows up on the first read address of the affected segment. It also shows up in the entry fields returned one response later. A wrong halfword choice or field decode gives a wrong physical address, cacheable flag or fault on the very next response. A stale or corrupted age state shows up as a missing, extra or wrongly masked write-back. The bench sees it in the cycle before the response pulse, and again on the next access to the same page. A broken busy interlock shows up as a second read or a mismatched response within the same transaction.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 18;
  localparam int PA_W   = 20;
  localparam int OFF_W  = 10;
  localparam int WORD_W = 36;
  localparam int HALF_W = WORD_W / 2;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int PAGE_W = VA_W - 1 - OFF_W;
  localparam int TIDX_W = PAGE_W - 1;
  localparam int NBASE  = 4;
  localparam int BIDX_W = $clog2(NBASE);

  // entry field positions within an 18-bit halfword
  localparam int ACC_HI  = 17;
  localparam int ACC_LO  = 16;
  localparam int AGE_BIT = 13;
  localparam int C_BIT   = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL,
    ST_WB,
    ST_RESP
  } ptw_state_e;

  typedef struct packed {
    logic             fault;
    logic             cache;
    logic             age_clr;
    logic [PPN_W-1:0] ppn;
  } ptw_result_t;
endpackage

// File: rtl/ptw_base_file.sv
module ptw_base_file
  import ptw_pkg::*;
#(
  parameter int N  = NBASE,
  parameter int AW = PA_W,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          exec_i,
  input  logic          high_i,
  output logic [AW-1:0] base_o
);
  logic [AW-1:0] base_q [N];
  logic [IW-1:0] sel;

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          base_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))    base_q[g] <= wdata_i;
    end
  end

  // user: low=0 high=1; exec: high=2 low=3
  assign sel    = {exec_i, exec_i ^ high_i};
  assign base_o = base_q[sel];
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              odd_i,
  input  logic              write_i,
  output ptw_result_t       res_o,
  output logic [WORD_W-1:0] wb_word_o
);
  logic [HALF_W-1:0] ent;
  logic [1:0]        acc;
  logic              allowed;
  logic              age;

  assign ent = odd_i ? word_i[HALF_W-1:0] : word_i[WORD_W-1:HALF_W];
  assign acc = ent[ACC_HI:ACC_LO];
  assign age = ent[AGE_BIT];

  always_comb begin
    unique case (acc)
      2'b00:        allowed = 1'b0;
      2'b01, 2'b10: allowed = !write_i;
      default:      allowed = 1'b1;
    endcase
  end

  always_comb begin
    res_o.fault   = !allowed;
    res_o.cache   = allowed & ent[C_BIT];
    res_o.age_clr = allowed & age;
    res_o.ppn     = allowed ? ent[PPN_W-1:0] : '0;
  end

  always_comb begin
    wb_word_o = word_i;
    if (odd_i) wb_word_o[AGE_BIT]          = 1'b0;
    else       wb_word_o[HALF_W + AGE_BIT] = 1'b0;
  end
endmodule

// File: rtl/seg_ptw.sv
module seg_ptw
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [1:0]        base_idx_i,
  input  logic [PA_W-1:0]   base_data_i,
  input  logic              req_i,
  output logic              ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic              req_exec_i,
  input  logic              req_write_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic              rsp_cache_o,
  output logic              rsp_age_clr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  ptw_state_e        state_q, state_d;
  logic [PA_W-1:0]   base;
  logic [PA_W-1:0]   taddr_q;
  logic              odd_q, wr_q;
  logic [OFF_W-1:0]  off_q;
  logic [WORD_W-1:0] word_q, wb_word_q, wb_word;
  ptw_result_t       res, res_q;
  logic              accept;

  ptw_base_file #(.N(NBASE), .AW(PA_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .widx_i  (base_idx_i),
    .wdata_i (base_data_i),
    .exec_i  (req_exec_i),
    .high_i  (req_vaddr_i[VA_W-1]),
    .base_o  (base)
  );

  ptw_entry_eval u_eval (
    .word_i    (word_q),
    .odd_i     (odd_q),
    .write_i   (wr_q),
    .res_o     (res),
    .wb_word_o (wb_word)
  );

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = ready_o && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (mem_rvalid_i) state_d = ST_EVAL;
      ST_EVAL:  state_d = res.age_clr ? ST_WB : ST_RESP;
      ST_WB:    state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      taddr_q   <= '0;
      odd_q     <= 1'b0;
      wr_q      <= 1'b0;
      off_q     <= '0;
      word_q    <= '0;
      wb_word_q <= '0;
      res_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        taddr_q <= base + PA_W'(req_vaddr_i[VA_W-2:OFF_W+1]);
        odd_q   <= req_vaddr_i[OFF_W];
        wr_q    <= req_write_i;
        off_q   <= req_vaddr_i[OFF_W-1:0];
      end
      if (state_q == ST_WAIT && mem_rvalid_i) word_q <= mem_rdata_i;
      if (state_q == ST_EVAL) begin
        res_q     <= res;
        wb_word_q <= wb_word;
      end
    end
  end

  assign mem_rd_o      = (state_q == ST_ISSUE);
  assign mem_wr_o      = (state_q == ST_WB);
  assign mem_addr_o    = taddr_q;
  assign mem_wdata_o   = wb_word_q;
  assign rsp_valid_o   = (state_q == ST_RESP);
  assign rsp_fault_o   = rsp_valid_o & res_q.fault;
  assign rsp_cache_o   = rsp_valid_o & res_q.cache;
  assign rsp_age_clr_o = rsp_valid_o & res_q.age_clr;
  assign rsp_paddr_o   = (rsp_valid_o && !res_q.fault) ? {res_q.ppn, off_q} : '0;

  p_rd_wr_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  p_wb_before_rsp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> rsp_valid_o && rsp_age_clr_o);
  p_fault_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> !rsp_age_clr_o && !rsp_cache_o && rsp_paddr_o == '0);
  p_accept_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o |=> mem_rd_o && !ready_o);
  p_rsp_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: tb/seg_ptw_tb.sv
module seg_ptw_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_we_i = 1'b0;
  logic [1:0]  base_idx_i = '0;
  logic [19:0] base_data_i = '0;
  logic        req_i = 1'b0;
  logic        ready_o;
  logic [17:0] req_vaddr_i = '0;
  logic        req_exec_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic        rsp_valid_o, rsp_fault_o, rsp_cache_o, rsp_age_clr_o;
  logic [19:0] rsp_paddr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [19:0] mem_addr_o;
  logic [35:0] mem_wdata_o;
  logic        mem_rvalid_i;
  logic [35:0] mem_rdata_i;

  always #5 clk_i = ~clk_i;

  seg_ptw u_dut (
    .clk_i, .rst_ni, .base_we_i, .base_idx_i, .base_data_i,
    .req_i, .ready_o, .req_vaddr_i, .req_exec_i, .req_write_i,
    .rsp_valid_o, .rsp_fault_o, .rsp_paddr_o, .rsp_cache_o, .rsp_age_clr_o,
    .mem_rd_o, .mem_wr_o, .mem_addr_o, .mem_wdata_o, .mem_rvalid_i, .mem_rdata_i
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [35:0] mem [256];
  logic        age_exp [4][128];
  int          rd_cnt = 0, wr_cnt = 0;
  logic [19:0] last_raddr, last_waddr;
  logic [35:0] last_wdata;
  logic        p0, p1;
  logic [19:0] a0;
  logic [35:0] d1;

  function automatic logic [19:0] base_of(int r);
    return 20'hA0000 + 20'(r * 64);
  endfunction

  function automatic logic [17:0] ent(int r, int p, logic age);
    logic [1:0] acc;
    logic [9:0] ppn;
    logic [6:0] pp;
    pp  = 7'(p);
    acc = 2'((p + r) % 4);
    ppn = 10'((p * 7 + r * 131) % 1024);
    return {acc, 2'b10, age, pp[3] ^ r[1], pp[5:4], ppn};
  endfunction

  function automatic logic [35:0] word_of(int r, int w);
    return {ent(r, 2*w, age_exp[r][2*w]), ent(r, 2*w+1, age_exp[r][2*w+1])};
  endfunction

  // memory model: two-cycle read latency
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p0 <= 1'b0; p1 <= 1'b0; a0 <= '0; d1 <= '0;
    end else begin
      p0 <= mem_rd_o;
      a0 <= mem_addr_o;
      p1 <= p0;
      d1 <= mem[a0[7:0]];
      if (mem_rd_o) begin
        rd_cnt     <= rd_cnt + 1;
        last_raddr <= mem_addr_o;
      end
      if (mem_wr_o) begin
        mem[mem_addr_o[7:0]] <= mem_wdata_o;
        wr_cnt     <= wr_cnt + 1;
        last_waddr <= mem_addr_o;
        last_wdata <= mem_wdata_o;
      end
    end
  end
  assign mem_rvalid_i = p1;
  assign mem_rdata_i  = d1;

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xlate(int r, int p, int off, bit wr, bit poke);
    logic [17:0] e;
    logic [35:0] w_before, w_exp;
    logic        high, exec, fault, age;
    logic [19:0] paddr;
    int rd0, wr0, n;
    exec = (r >= 2);
    high = (r == 1 || r == 2);
    e = ent(r, p, age_exp[r][p]);
    age = e[13];
    fault = (e[17:16] == 2'b00) || (wr && e[17:16] != 2'b11);
    paddr = fault ? 20'h0 : {e[9:0], 10'(off)};
    w_before = word_of(r, p / 2);
    w_exp = w_before;
    if (p % 2 == 1) w_exp[13] = 1'b0; else w_exp[31] = 1'b0;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk_i);
    req_i = 1'b1; req_exec_i = exec; req_write_i = wr;
    req_vaddr_i = {high, 7'(p), 10'(off)};
    @(negedge clk_i);
    req_i = 1'b0;
    if (poke) begin
      chk(ready_o == 1'b0, "R9 busy after accept", 36'(ready_o), 36'h0);
      req_i = 1'b1; req_vaddr_i = ~req_vaddr_i; req_write_i = ~wr;
      @(negedge clk_i);
      @(negedge clk_i);
      req_i = 1'b0;
    end
    n = 0;
    while (!rsp_valid_o && n < 50) begin
      @(negedge clk_i);
      n++;
    end
    chk(rsp_valid_o == 1'b1, "R11 response arrives", 36'(rsp_valid_o), 36'h1);
    chk(rd_cnt - rd0 == 1, "R2 one read", 36'(rd_cnt - rd0), 36'h1);
    chk(last_raddr == base_of(r) + 20'(p / 2), "R1 R2 table address",
        36'(last_raddr), 36'(base_of(r) + 20'(p / 2)));
    chk(rsp_fault_o == fault, "R5 fault", 36'(rsp_fault_o), 36'(fault));
    chk(rsp_paddr_o == paddr, "R3 R4 R6 paddr", 36'(rsp_paddr_o), 36'(paddr));
    chk(rsp_cache_o == (!fault && e[12]), "R6 cacheable",
        36'(rsp_cache_o), 36'(!fault && e[12]));
    chk(rsp_age_clr_o == (!fault && age), "R7 R8 age flag",
        36'(rsp_age_clr_o), 36'(!fault && age));
    if (!fault && age) begin
      chk(wr_cnt - wr0 == 1, "R7 one write-back", 36'(wr_cnt - wr0), 36'h1);
      chk(last_waddr == last_raddr, "R7 write-back address", 36'(last_waddr), 36'(last_raddr));
      chk(last_wdata == w_exp, "R7 write-back data", last_wdata, w_exp);
      age_exp[r][p] = 1'b0;
    end else begin
      chk(wr_cnt == wr0, "R8 no write", 36'(wr_cnt - wr0), 36'h0);
    end
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R11 single pulse", 36'(rsp_valid_o), 36'h0);
    chk(ready_o == 1'b1, "R9 ready after response", 36'(ready_o), 36'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 128; p++)
        age_exp[r][p] = p[2];
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int r = 0; r < 4; r++)
      for (int w = 0; w < 64; w++)
        mem[r * 64 + w] = word_of(r, w);
    repeat (3) @(negedge clk_i);
    chk(ready_o == 1'b1, "R10 ready in reset", 36'(ready_o), 36'h1);
    chk(rsp_valid_o == 1'b0, "R10 no response", 36'(rsp_valid_o), 36'h0);
    chk(mem_rd_o == 1'b0 && mem_wr_o == 1'b0, "R10 memory idle",
        36'({mem_rd_o, mem_wr_o}), 36'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int r = 0; r < 4; r++) begin
      base_we_i = 1'b1; base_idx_i = 2'(r); base_data_i = base_of(r);
      @(negedge clk_i);
    end
    base_we_i = 1'b0;
    // R1 R3 R5 sweep: every segment, page, read then write
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 128; p++) begin
        xlate(r, p, (p * 37 + r * 5) % 1024, 1'b0, 1'b0);
        xlate(r, p, (p * 53 + r * 11 + 7) % 1024, 1'b1, 1'b0);
      end
    // R9: requests while busy are ignored
    for (int p = 0; p < 8; p++)
      xlate(p % 4, 3 + p * 13, 1023 - p, p[0], 1'b1);
    // R7 R8: second sweep after ages cleared, no write-backs expected
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 128; p += 5)
        xlate(r, p, p, 1'b0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule